// File: doc/BRIEF.md
# Sampled Lead/Lag Phase and Frequency Comparator

This block decides which of two slow clocks, a reference and a feedback clock, is ahead of the other. Both clocks enter as ordinary data inputs. A faster system clock samples them through a synchronizer, so every flop in the design runs on that one system clock. A three-state machine turns the synchronized levels into a pair of phase flags. `lead_q1` high means the reference leads and the feedback must speed up. `lead_q2` high means the feedback leads and must slow down.

A second stage watches only the two phase flags. It raises a frequency-direction pair, `freq_up` and `freq_dn`. `freq_up` high means the feedback frequency is too low. `freq_dn` high means it is too high. A direction is reported only after its phase flag has stayed high for a run of system cycles. The length of that run is set by the `hold_len` input.

A loop controller uses the phase pair for fine correction and the frequency pair for coarse correction. When the two clocks match in phase and frequency, all four flags stay low.

The three states of the machine are:
- ST_IDLE, encoded lead_q1/lead_q2 = 00.
- ST_REF_LEAD, encoded 10.
- ST_FB_LEAD, encoded 01.

The machine has four named transitions:
- ENTER_REF, from ST_IDLE to ST_REF_LEAD.
- ENTER_FB, from ST_IDLE to ST_FB_LEAD.
- RELEASE, from either lead state back to ST_IDLE.
- HOLD, a lead state staying where it is.

Top module: `phase_lead_cmp`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a `clk` edge, puts the machine in ST_IDLE, clears the synchronizers and the run counters, and so drives all four outputs low from that edge.
- R2: Each clock input takes effect through a two-stage synchronizer. A level presented before edge k reaches the state register at edge k+2. In ST_IDLE, with the reference high and the feedback low, the machine takes ENTER_REF to ST_REF_LEAD, where lead_q1=1 and lead_q2=0.
- R3: In ST_IDLE, with the feedback high and the reference low, the machine takes ENTER_FB to ST_FB_LEAD, where lead_q1=0 and lead_q2=1.
- R4: A lead state takes HOLD while the synchronized levels differ. It takes RELEASE to ST_IDLE as soon as the two levels are equal, whether both are low or both are high.
- R5: In ST_IDLE with equal synchronized levels, the machine stays in ST_IDLE. lead_q1 and lead_q2 are never high together.
- R6: `freq_up` is high exactly when lead_q1 is high and lead_q1 was also high on at least `hold_len` immediately preceding cycles. The run count saturates at 2^CNT_W-1. With hold_len=0, freq_up equals lead_q1.
- R7: `freq_dn` follows the same rule from lead_q2, and drops in the same cycle that lead_q2 drops.
- R8: freq_up and freq_dn are never high in the same cycle. If both conditions hold at once, both outputs are forced low.
- R9: With the reference and feedback clocks equal in phase and frequency, all four outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both compared clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, sampled as data |
| fb_in | input | 1 | Feedback clock, sampled as data |
| hold_len | input | CNT_W | Consecutive phase-flag cycles needed before a frequency direction is raised |
| lead_q1 | output | 1 | Reference leads (state 10) |
| lead_q2 | output | 1 | Feedback leads (state 01) |
| freq_up | output | 1 | Feedback frequency too low |
| freq_dn | output | 1 | Feedback frequency too high |

## Verification
The bench builds the block with the default CNT_W=8. It drives `hold_len` with the values 0, 2, 5 and 255:
- hold_len=0 shows the frequency flags tracking the phase flags directly.
- hold_len=2 and hold_len=5 let short phase pulses be either filtered out or passed.
- hold_len=255, paired with a reference held high against a low feedback for several hundred cycles, drives the run counter to its saturation limit.

The clock patterns cover four cases: matched clocks, a fixed reference lead, a fixed feedback lead, and unequal periods in both directions. Together these exercise RELEASE from both the both-low and the both-high condition.

// File: rtl/pld_pkg.sv
package pld_pkg;
    // State code doubles as the phase flag pair {lead_q1, lead_q2}
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_REF_LEAD = 2'b10,
        ST_FB_LEAD  = 2'b01
    } lead_state_t;
endpackage

// File: rtl/pld_level_sync.sv
module pld_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pld_lead_fsm.sv
module pld_lead_fsm
    import pld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_s,
    input  logic fb_s,
    output logic q1,
    output logic q2
);
    lead_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_s && !fb_s)      state_nx = ST_REF_LEAD;  // ENTER_REF
                else if (fb_s && !ref_s) state_nx = ST_FB_LEAD;   // ENTER_FB
            end
            ST_REF_LEAD, ST_FB_LEAD: begin
                if (ref_s == fb_s)       state_nx = ST_IDLE;      // RELEASE
            end
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        q1 = 1'b0;
        q2 = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_REF_LEAD: q1 = 1'b1;
            ST_FB_LEAD:  q2 = 1'b1;
            default:     ;
        endcase
    end

    // R1 reset lands in idle
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (state == ST_IDLE));
    // R2 enter reference-lead
    a_r2_enter_ref: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && ref_s && !fb_s) |=> (q1 && !q2));
    // R3 enter feedback-lead
    a_r3_enter_fb: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fb_s && !ref_s) |=> (q2 && !q1));
    // R4 hold while levels differ, release when equal
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && ref_s != fb_s) |=> $stable(state));
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && ref_s == fb_s) |=> (!q1 && !q2));
    // R5 idle with equal levels stays idle
    a_r5_idle_stay: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && ref_s == fb_s) |=> (!q1 && !q2));
endmodule

// File: rtl/pld_freq_stage.sv
module pld_freq_stage #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q1,
    input  logic             q2,
    input  logic [CNT_W-1:0] hold_len,
    output logic             up,
    output logic             dn
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run [2];
    logic [1:0]       flag;
    logic [1:0]       want;

    assign flag = {q2, q1};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_run
            always_ff @(posedge clk) begin
                if (rst || !flag[i])        run[i] <= '0;
                else if (run[i] != CNT_MAX) run[i] <= run[i] + 1'b1;
            end
            assign want[i] = flag[i] && (run[i] >= hold_len);
        end
    endgenerate

    // Conflicting requests cancel each other
    assign up = want[0] && !want[1];
    assign dn = want[1] && !want[0];

    // R8 never both directions
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst) !(up && dn));
    // R6 a fresh phase flag with nonzero hold does not raise up at once
    a_r6_delay: assert property (@(posedge clk) disable iff (rst)
        (hold_len != '0 && q1 && !$past(q1)) |-> !up);
    // R6 up only with q1
    a_r6_needs_q1: assert property (@(posedge clk) disable iff (rst) !q1 |-> !up);
    // R7 down drops with q2
    a_r7_needs_q2: assert property (@(posedge clk) disable iff (rst) !q2 |-> !dn);
endmodule

// File: rtl/phase_lead_cmp.sv
module phase_lead_cmp #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] hold_len,
    output logic             lead_q1,
    output logic             lead_q2,
    output logic             freq_up,
    output logic             freq_dn
);
    logic ref_s, fb_s;

    pld_level_sync #(.STAGES(SYNC_STAGES)) i_sync_ref (
        .clk(clk), .rst(rst), .din(ref_in), .dout(ref_s));
    pld_level_sync #(.STAGES(SYNC_STAGES)) i_sync_fb (
        .clk(clk), .rst(rst), .din(fb_in), .dout(fb_s));

    pld_lead_fsm i_fsm (
        .clk(clk), .rst(rst), .ref_s(ref_s), .fb_s(fb_s),
        .q1(lead_q1), .q2(lead_q2));

    pld_freq_stage #(.CNT_W(CNT_W)) i_freq (
        .clk(clk), .rst(rst), .q1(lead_q1), .q2(lead_q2),
        .hold_len(hold_len), .up(freq_up), .dn(freq_dn));

    // R5 phase flags exclusive at the top
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lead_q1 && lead_q2));
endmodule

// File: tb/test_phase_lead_cmp.sv
module test_phase_lead_cmp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [7:0] hold_len = 8'd0;
    logic       lead_q1, lead_q2, freq_up, freq_dn;

    int tests = 0;
    int fails = 0;
    int seen_up = 0;
    int seen_dn = 0;
    int seen_any = 0;

    // Behavioural reference
    int   m_state = 0;           // 0 idle, 1 ref leads, 2 fb leads
    int   m_c1 = 0;
    int   m_c2 = 0;
    bit   qr[$];
    bit   qf[$];
    logic m_q1, m_q2, m_up, m_dn;

    phase_lead_cmp i_phase_lead_cmp (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .hold_len(hold_len), .lead_q1(lead_q1), .lead_q2(lead_q2),
        .freq_up(freq_up), .freq_dn(freq_dn));

    always #5 clk = ~clk;

    initial begin
        qr = '{1'b0, 1'b0};
        qf = '{1'b0, 1'b0};
    end

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_c1 = 0; m_c2 = 0;
            qr = '{1'b0, 1'b0};
            qf = '{1'b0, 1'b0};
        end else begin
            bit rs, fs;
            rs = qr.pop_front();
            fs = qf.pop_front();
            qr.push_back(ref_in);
            qf.push_back(fb_in);
            m_c1 = (m_state == 1) ? ((m_c1 < 255) ? m_c1 + 1 : 255) : 0;
            m_c2 = (m_state == 2) ? ((m_c2 < 255) ? m_c2 + 1 : 255) : 0;
            if (m_state == 0) begin
                if (rs && !fs)      m_state = 1;
                else if (fs && !rs) m_state = 2;
            end else if (rs == fs) begin
                m_state = 0;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        m_q1 = (m_state == 1);
        m_q2 = (m_state == 2);
        m_up = m_q1 && (m_c1 >= int'(hold_len));
        m_dn = m_q2 && (m_c2 >= int'(hold_len));
        chk("R2 R4 lead_q1", lead_q1, m_q1);
        chk("R3 R4 lead_q2", lead_q2, m_q2);
        chk("R6 freq_up", freq_up, m_up);
        chk("R7 freq_dn", freq_dn, m_dn);
        chk("R8 up/dn exclusive", freq_up && freq_dn, 1'b0);
        chk("R5 q1/q2 exclusive", lead_q1 && lead_q2, 1'b0);
        if (freq_up) seen_up++;
        if (freq_dn) seen_dn++;
        if (lead_q1 || lead_q2 || freq_up || freq_dn) seen_any++;
    end

    // Drive both clocks on falling edges; fb is delayed by off cycles
    task automatic run_pattern(input int pr, input int pf, input int off, input int cyc);
        for (int n = 0; n < cyc; n++) begin
            @(negedge clk);
            ref_in = (n % pr) < (pr / 2);
            fb_in  = ((n + 1000 * pf - off) % pf) < (pf / 2);
        end
    endtask

    task automatic do_reset(input logic [7:0] h);
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0; hold_len = h;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset q1", lead_q1, 1'b0);
        chk("R1 reset q2", lead_q2, 1'b0);
        chk("R1 reset up", freq_up, 1'b0);
        chk("R1 reset dn", freq_dn, 1'b0);
        rst = 1'b0;

        // R9 matched clocks
        seen_any = 0;
        run_pattern(8, 8, 0, 200);
        chk("R9 matched clocks all low", seen_any != 0, 1'b0);

        // R2 R6 reference leads, hold 2
        do_reset(8'd2);
        seen_up = 0;
        run_pattern(12, 12, 4, 300);
        chk("R6 up seen with ref lead", seen_up > 0, 1'b1);

        // R3 R7 feedback leads, hold 0
        do_reset(8'd0);
        seen_dn = 0;
        run_pattern(12, 12, 8, 300);
        chk("R7 dn seen with fb lead", seen_dn > 0, 1'b1);

        // R6 long hold filters short pulses
        do_reset(8'd5);
        seen_up = 0;
        run_pattern(12, 12, 2, 300);
        chk("R6 short lead filtered", seen_up > 0, 1'b0);

        // R4 unequal periods, both directions
        do_reset(8'd2);
        run_pattern(10, 14, 0, 600);
        do_reset(8'd2);
        run_pattern(14, 10, 0, 600);

        // R6 saturation with hold 255
        do_reset(8'd255);
        seen_up = 0;
        @(negedge clk); ref_in = 1'b1; fb_in = 1'b0;
        repeat (400) @(negedge clk);
        chk("R6 up after 255 held cycles", seen_up > 0, 1'b1);
        @(negedge clk); fb_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R4 release on both high", lead_q1, 1'b0);

        // R1 reset mid-activity
        @(negedge clk); fb_in = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset q1", lead_q1, 1'b0);
        chk("R1 mid-run reset up", freq_up, 1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule